// File: doc/BRIEF.md
# Floating-Point Status to Condition Field Move Unit

This execution unit carries out one instruction that moves a floating-point status field into the condition register. It keeps a 32-bit floating-point status and control word, a 32-bit condition register made of eight 4-bit fields, and a program counter. When an instruction word arrives with its valid strobe, the unit decodes it. On a match it copies the chosen 4-bit status field into the chosen condition field. It then resets the sticky exception flags that lie inside that status field and rebuilds the invalid-operation summary flag and the enabled-exception summary flag.

Every update to the three registers commits at the same clock edge that raises the one-cycle `done` pulse. An instruction word that fails decode leaves all state unchanged and raises `illegal` for one cycle instead. The status, condition and program counter registers are also written by other units in the core. They deliver their results through a load port, which takes priority over a move arriving in the same cycle.

Bit positions below use LSB-0 numbering on 32-bit words: bit 31 is the most significant bit. Status field `s` occupies bits `31-4s` down to `28-4s`, and condition field `d` is laid out the same way.

Top module: `fcm_move_unit`

## Requirements
- R1: An instruction word is a legal move when bits 31:26 equal 63, bits 10:1 equal 64, bit 0 is 0, and the reserved bits 22:21 and 17:11 are all 0. A legal move offered with `instrValid` gives `done`=1 in the next cycle only.
- R2: The source field index is instruction bits 20:18. The value copied is the status field selected by that index, taken as it was before any clearing.
- R3: The destination field index is instruction bits 25:23. The copied nibble lands in that condition field with its most significant bit in the field's top bit (the LT position).
- R4: Inside the source field, the bits set in mask 0x9FF80700 are cleared. All other status bits are left unchanged, except bits 30 and 29.
- R5: No condition field other than the destination changes.
- R6: After clearing, status bit 29 (VX) equals the OR of the status bits in mask 0x01F80700.
- R7: After clearing, status bit 30 (FEX) equals (b29&b7)|(b28&b6)|(b27&b5)|(b26&b4)|(b25&b3).
- R8: A legal move adds 4 to the program counter. This happens in the same cycle as `done` and the register updates.
- R9: A word that fails decode raises `illegal` for one cycle and does not raise `done`. The status, condition and program counter registers stay unchanged.
- R10: `ldValid` writes `ldFpscr`, `ldCr` and `ldPc` at the next edge. An instruction offered in the same cycle is discarded, so neither `done` nor `illegal` is raised.
- R11: After reset, status and condition registers are 0, the program counter is RESET_PC (default 0), and `done` and `illegal` are 0.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction word strobe |
| instrWord | input | 32 | Instruction word |
| ldValid | input | 1 | Register load strobe from other units |
| ldFpscr | input | 32 | Status word to load |
| ldCr | input | 32 | Condition register to load |
| ldPc | input | 32 | Program counter to load |
| fpscrOut | output | 32 | Current status and control word |
| crOut | output | 32 | Current condition register |
| pcOut | output | 32 | Current program counter |
| done | output | 1 | One-cycle pulse when a move commits |
| illegal | output | 1 | One-cycle pulse when a word fails decode |

## Verification
The move is tried with a fully set status word, where only the sticky bits of the chosen field may drop. It is also tried with status words that hold a single invalid-operation flag, which shows whether VX follows the flags that remain, and with enabled-exception pairs placed inside and outside the chosen field, which shows whether FEX is rebuilt from the cleared value. Fields holding reserved, rounding and result-class bits show that non-sticky bits survive. Differing source and destination indices together with a busy condition register show that the nibble comes from the pre-clear value and lands in the right field only. Words with a wrong primary code, a wrong extended code, the record bit set or a reserved bit set, and a load that collides with a move, show that state is held and the right pulse appears.

// File: rtl/fcm_pkg.sv
package fcm_pkg;
  localparam int XLEN  = 32;
  localparam int CRF_W = 4;
  localparam int CRF_N = XLEN / CRF_W;
  localparam int IDX_W = $clog2(CRF_N);

  localparam logic [5:0] PRIMARY_CODE  = 6'd63;
  localparam logic [9:0] EXTENDED_CODE = 10'd64;

  // Sticky flags a move may reset, and the individual invalid-operation flags
  localparam logic [XLEN-1:0] STICKY_MASK  = 32'h9FF8_0700;
  localparam logic [XLEN-1:0] INVALID_MASK = 32'h01F8_0700;

  localparam int FEX_POS = 30;
  localparam int VX_POS  = 29;
  localparam int OX_POS  = 28;
  localparam int UX_POS  = 27;
  localparam int ZX_POS  = 26;
  localparam int XX_POS  = 25;
  localparam int VE_POS  = 7;
  localparam int OE_POS  = 6;
  localparam int UE_POS  = 5;
  localparam int ZE_POS  = 4;
  localparam int XE_POS  = 3;

  typedef struct packed {
    logic load;    // external register load
    logic commit;  // legal move executes
    logic reject;  // decode failed
  } ctrlStrobe_t;
endpackage

// File: rtl/fcm_ctrl.sv
module fcm_ctrl
  import fcm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instrValid,
  input  logic [XLEN-1:0]  instrWord,
  input  logic             ldValid,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] dstIdx,
  output logic             done,
  output logic             illegal
);
  logic isMatch;

  always_comb begin
    isMatch = (instrWord[31:26] == PRIMARY_CODE) &&
              (instrWord[10:1] == EXTENDED_CODE) &&
              !instrWord[0] &&
              (instrWord[22:21] == '0) &&
              (instrWord[17:11] == '0);
    strobe.load   = ldValid;
    strobe.commit = instrValid && !ldValid && isMatch;
    strobe.reject = instrValid && !ldValid && !isMatch;
    dstIdx = instrWord[25:23];
    srcIdx = instrWord[20:18];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= strobe.commit;
      illegal <= strobe.reject;
    end
  end
endmodule

// File: rtl/fcm_datapath.sv
module fcm_datapath
  import fcm_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  parameter int PC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [XLEN-1:0]  ldFpscr,
  input  logic [XLEN-1:0]  ldCr,
  input  logic [PC_W-1:0]  ldPc,
  output logic [XLEN-1:0]  fpscrQ,
  output logic [XLEN-1:0]  crQ,
  output logic [PC_W-1:0]  pcQ
);
  localparam int SHIFT_W = $clog2(XLEN);

  logic [SHIFT_W-1:0] srcBase;
  logic [CRF_W-1:0]   srcNibble;
  logic [XLEN-1:0]    fieldMask;
  logic [XLEN-1:0]    cleared;
  logic [XLEN-1:0]    fpscrNext;
  logic [XLEN-1:0]    crNext;
  logic               vxNew;
  logic               fexNew;

  always_comb begin
    // field s starts at bit 4*(CRF_N-1-s)
    srcBase   = SHIFT_W'((CRF_N - 1 - int'(srcIdx)) * CRF_W);
    srcNibble = fpscrQ[srcBase +: CRF_W];
    fieldMask = {{(XLEN-CRF_W){1'b0}}, {CRF_W{1'b1}}} << srcBase;
    cleared   = fpscrQ & ~(fieldMask & STICKY_MASK);
    vxNew     = |(cleared & INVALID_MASK);
    fexNew    = (vxNew & cleared[VE_POS]) |
                (cleared[OX_POS] & cleared[OE_POS]) |
                (cleared[UX_POS] & cleared[UE_POS]) |
                (cleared[ZX_POS] & cleared[ZE_POS]) |
                (cleared[XX_POS] & cleared[XE_POS]);
    fpscrNext = cleared;
    fpscrNext[VX_POS]  = vxNew;
    fpscrNext[FEX_POS] = fexNew;
  end

  for (genvar g = 0; g < CRF_N; g++) begin : g_crField
    assign crNext[(CRF_N-1-g)*CRF_W +: CRF_W] =
      (dstIdx == IDX_W'(g)) ? srcNibble : crQ[(CRF_N-1-g)*CRF_W +: CRF_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fpscrQ <= '0;
      crQ    <= '0;
      pcQ    <= RESET_PC;
    end else if (strobe.load) begin
      fpscrQ <= ldFpscr;
      crQ    <= ldCr;
      pcQ    <= ldPc;
    end else if (strobe.commit) begin
      fpscrQ <= fpscrNext;
      crQ    <= crNext;
      pcQ    <= pcQ + PC_W'(PC_STEP);
    end
  end
endmodule

// File: rtl/fcm_move_unit.sv
module fcm_move_unit
  import fcm_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instrValid,
  input  logic [XLEN-1:0] instrWord,
  input  logic            ldValid,
  input  logic [XLEN-1:0] ldFpscr,
  input  logic [XLEN-1:0] ldCr,
  input  logic [PC_W-1:0] ldPc,
  output logic [XLEN-1:0] fpscrOut,
  output logic [XLEN-1:0] crOut,
  output logic [PC_W-1:0] pcOut,
  output logic            done,
  output logic            illegal
);
  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] srcIdx;
  logic [IDX_W-1:0] dstIdx;

  fcm_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .ldValid(ldValid), .strobe(strobe), .srcIdx(srcIdx), .dstIdx(dstIdx),
    .done(done), .illegal(illegal)
  );

  fcm_datapath #(.PC_W(PC_W), .RESET_PC(RESET_PC), .PC_STEP(4)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .srcIdx(srcIdx), .dstIdx(dstIdx),
    .ldFpscr(ldFpscr), .ldCr(ldCr), .ldPc(ldPc),
    .fpscrQ(fpscrOut), .crQ(crOut), .pcQ(pcOut)
  );
endmodule

// File: rtl/fcm_checker.sv
module fcm_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instrValid,
  input logic            ldValid,
  input logic [2:0]      dstField,
  input logic [31:0]     fpscrOut,
  input logic [31:0]     crOut,
  input logic [PC_W-1:0] pcOut,
  input logic            done,
  input logic            illegal
);
  a_r1_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(instrValid) && !$past(ldValid)));

  a_r9_illegal_holds_state: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!done && $stable(fpscrOut) && $stable(crOut) && $stable(pcOut)));

  a_r8_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pcOut == $past(pcOut) + PC_W'(4)));

  a_r5_other_fields: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((crOut ^ $past(crOut)) & ~(32'hF << {~$past(dstField), 2'b00})) == 32'h0));

  a_r6_vx_summary: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fpscrOut[29] == |(fpscrOut & 32'h01F8_0700)));

  a_r7_fex_summary: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fpscrOut[30] == ((fpscrOut[29] & fpscrOut[7]) | (fpscrOut[28] & fpscrOut[6]) |
                               (fpscrOut[27] & fpscrOut[5]) | (fpscrOut[26] & fpscrOut[4]) |
                               (fpscrOut[25] & fpscrOut[3]))));

  a_r4_only_sticky_drop: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((fpscrOut & ~$past(fpscrOut) & ~32'h6000_0000) == 32'h0));
endmodule

bind fcm_move_unit fcm_checker #(.PC_W(PC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .ldValid(ldValid),
  .dstField(instrWord[25:23]), .fpscrOut(fpscrOut), .crOut(crOut), .pcOut(pcOut),
  .done(done), .illegal(illegal)
);

// File: tb/fcm_move_unit_tb_top.sv
module fcm_move_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instrValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic ldValid = 1'b0;
  logic [31:0] ldFpscr = '0, ldCr = '0, ldPc = '0;
  logic [31:0] fpscrOut, crOut, pcOut;
  logic done, illegal;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fcm_move_unit dut_i (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .ldValid(ldValid), .ldFpscr(ldFpscr), .ldCr(ldCr), .ldPc(ldPc),
    .fpscrOut(fpscrOut), .crOut(crOut), .pcOut(pcOut), .done(done), .illegal(illegal)
  );

  typedef struct packed {
    logic [31:0] fp;
    logic [31:0] cr;
    logic [2:0]  d;
    logic [2:0]  s;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VEC [NVEC] = '{
    '{32'hFFFF_FFFF, 32'h0000_0000, 3'd0, 3'd0},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd7, 3'd1},
    '{32'h01F8_0700, 32'h1234_5678, 3'd3, 3'd2},
    '{32'h2100_0000, 32'h8765_4321, 3'd2, 3'd1},
    '{32'h5000_0040, 32'h0F0F_0F0F, 3'd5, 3'd0},
    '{32'h5000_0040, 32'hF0F0_F0F0, 3'd1, 3'd3},
    '{32'h0000_0F00, 32'h0000_0000, 3'd4, 3'd5},
    '{32'h0000_000F, 32'h3333_3333, 3'd6, 3'd7},
    '{32'h4E00_0FF8, 32'hAAAA_5555, 3'd0, 3'd6},
    '{32'h4E00_0FF8, 32'hAAAA_5555, 3'd1, 3'd1},
    '{32'h6000_00F0, 32'h0000_0000, 3'd7, 3'd0}
  };

  function automatic logic [31:0] mkInstr(logic [2:0] d, logic [2:0] s);
    return 32'hFC00_0080 | (32'(d) << 23) | (32'(s) << 18);
  endfunction

  // Expected status word, built from MSB-0 flag positions
  function automatic logic [31:0] modelFp(logic [31:0] fp, int s);
    logic [31:0] r = fp;
    logic vx, fex;
    for (int k = 0; k < 4; k++) begin
      int pos = 4 * s + k;
      if (pos inside {0, 3, 4, 5, 6, 7, 8, 9, 10, 11, 12, 21, 22, 23}) r[31-pos] = 1'b0;
    end
    vx = r[31-7] | r[31-8] | r[31-9] | r[31-10] | r[31-11] | r[31-12] |
         r[31-21] | r[31-22] | r[31-23];
    r[31-2] = vx;
    fex = (vx & r[31-24]) | (r[31-3] & r[31-25]) | (r[31-4] & r[31-26]) |
          (r[31-5] & r[31-27]) | (r[31-6] & r[31-28]);
    r[31-1] = fex;
    return r;
  endfunction

  function automatic logic [31:0] modelCr(logic [31:0] cr, logic [31:0] fp, int d, int s);
    logic [31:0] r = cr;
    r[31-4*d -: 4] = fp[31-4*s -: 4];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadRegs(logic [31:0] fp, logic [31:0] cr, logic [31:0] pc);
    @(negedge clk);
    ldValid = 1'b1; ldFpscr = fp; ldCr = cr; ldPc = pc;
    @(negedge clk);
    ldValid = 1'b0;
  endtask

  task automatic issue(logic [31:0] w);
    instrValid = 1'b1; instrWord = w;
    @(negedge clk);
    instrValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 fpscr", fpscrOut, 32'h0);
    check("R11 cr", crOut, 32'h0);
    check("R11 pc", pcOut, 32'h0);
    check("R11 done/illegal", {30'b0, done, illegal}, 32'h0);
    rst_n = 1'b1;

    // R2 R3 R4 R5 R6 R7 R8 vector walk
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] pcStart = 32'h0000_1000 + 32'(i) * 32'h40;
      loadRegs(VEC[i].fp, VEC[i].cr, pcStart);
      issue(mkInstr(VEC[i].d, VEC[i].s));
      check("R1 done", {31'b0, done}, 32'h1);
      check("R4 R6 R7 fpscr", fpscrOut, modelFp(VEC[i].fp, int'(VEC[i].s)));
      check("R2 R3 R5 cr", crOut, modelCr(VEC[i].cr, VEC[i].fp, int'(VEC[i].d), int'(VEC[i].s)));
      check("R8 pc", pcOut, pcStart + 32'd4);
    end
    // R1 pulse lasts one cycle
    @(negedge clk);
    check("R1 done single cycle", {31'b0, done}, 32'h0);

    // R9 words that fail decode
    begin
      logic [31:0] badWords [4] = '{32'hF800_0080, 32'hFC00_0082, 32'hFC00_0081, 32'hFC20_0080};
      foreach (badWords[j]) begin
        loadRegs(32'hFFFF_FFFF, 32'h1357_9BDF, 32'h0000_2000);
        issue(badWords[j] | (32'd3 << 23) | (32'd2 << 18));
        check("R9 illegal", {30'b0, done, illegal}, 32'h1);
        check("R9 fpscr held", fpscrOut, 32'hFFFF_FFFF);
        check("R9 cr held", crOut, 32'h1357_9BDF);
        check("R9 pc held", pcOut, 32'h0000_2000);
      end
    end

    // R10 load collides with a legal move
    loadRegs(32'hFFFF_FFFF, 32'h0, 32'h0000_3000);
    ldValid = 1'b1; ldFpscr = 32'h9000_0000; ldCr = 32'hCAFE_F00D; ldPc = 32'h0000_4000;
    instrValid = 1'b1; instrWord = mkInstr(3'd0, 3'd0);
    @(negedge clk);
    ldValid = 1'b0; instrValid = 1'b0;
    check("R10 no pulse", {30'b0, done, illegal}, 32'h0);
    check("R10 fpscr loaded", fpscrOut, 32'h9000_0000);
    check("R10 cr loaded", crOut, 32'hCAFE_F00D);
    check("R10 pc loaded", pcOut, 32'h0000_4000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule